// File: doc/BRIEF.md
# Transport Stream PID Filter

This block sits on a byte-wide MPEG transport stream and decides, packet by packet, whether each 188-byte packet moves on to a capture stage. The input is one byte per valid cycle, with a strobe that marks the first byte of each packet. The block takes the 13-bit packet identifier from the packet header and checks it against a bank of eight filter slots. Accepted bytes are gathered into 32-bit words. Dropped packets produce no words.

A small register port lets a host load the slots and read them back. Each slot holds an identifier and an enable bit. Slot 0 also holds three global controls: one blocks every packet, one passes every packet whatever its identifier, and one picks the byte order inside each output word. At the end of every framed packet the block gives a one-cycle pulse that reports whether the packet was accepted.

Top module: `tsf_pid_filter`

## Requirements
- R1: After reset every slot reads back with its enable bit (bit 15) clear and its identifier field (bits 12:0) at the null value 0x1FFF. Slot 0 also reads with bit 13 (block-all) set, so the reset value of slot 0 is 0x03FFF and the others read 0x01FFF. No output word and no end-of-packet pulse appear until a packet is received.
- R2: Slot n is reached at byte address n*4, and address bits 1:0 are ignored. A write takes effect on the next read. In slots 1 to 7 only bits 15 and 12:0 are stored, and all other bits read 0. Slot 0 also stores bit 13 (block-all), bit 14 (byte order) and bit 16 (pass-all).
- R3: The identifier is the low 5 bits of packet byte 1, placed above all 8 bits of packet byte 2; the upper 3 bits of byte 1 are ignored. A packet is accepted when some slot with its enable bit set holds that identifier. A slot whose enable bit is clear never accepts, even when its identifier matches.
- R4: While block-all is set, every packet is dropped, even when pass-all is also set or a slot matches.
- R5: While pass-all is set and block-all is clear, every packet with a good sync byte is accepted, whatever its identifier.
- R6: If the first byte of a packet is not 0x47, the whole packet is dropped, whatever the slots hold.
- R7: An accepted packet of 188 bytes yields 47 output words. A word is valid for exactly one cycle, on the cycle after the clock edge that samples packet byte 4k+3. A dropped packet yields no words.
- R8: With the byte-order bit clear, packet byte 4k sits in bits 31:24 of its word and byte 4k+3 sits in bits 7:0. With the bit set, the order is reversed and byte 4k sits in bits 7:0.
- R9: One cycle after the edge that samples byte 187 of a framed packet, the end-of-packet strobe pulses for one cycle. The accepted flag beside it is 1 if the packet was accepted and 0 if it was dropped.
- R10: Cycles with the valid input low are skipped and do not break a packet. A start strobe in the middle of a packet restarts framing at byte 0. Valid bytes that arrive outside a packet and without a start strobe are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_byte | input | 8 | Stream byte |
| ts_valid | input | 1 | Stream byte is present this cycle |
| ts_start | input | 1 | Stream byte is the first byte of a packet |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte address; slot index in bits 4:2 |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| cap_word | output | 32 | Packed word of accepted bytes |
| cap_valid | output | 1 | cap_word is valid this cycle |
| pkt_end | output | 1 | Pulse after the last byte of a framed packet |
| pkt_accepted | output | 1 | Accept result of the packet that pkt_end reports |

## Verification
Every result is due at a fixed point after the stimulus that causes it. A word arrives one cycle after the edge that samples byte 4k+3, and the end-of-packet pulse arrives one cycle after the edge that samples byte 187. Register writes are visible on the next read, and read data is combinational from the address. The driver changes inputs on the falling edge, so the rising edge samples them. The monitor also checks on the falling edge, just after each registered output changes, and compares every valid word and pulse against the front of an expected queue that the driver filled from its own model of the slots. Any pulse that arrives with an empty queue counts as a mismatch, and so does any entry still left in the queues at the end.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int PKT_LEN  = 188;
  localparam int CNT_W    = $clog2(PKT_LEN);
  localparam int PID_W    = 13;
  localparam int SLOT_W   = 17;
  localparam logic [7:0] SYNC_BYTE = 8'h47;
  localparam logic [PID_W-1:0] NULL_PID = 13'h1FFF;
  // bit positions inside a slot word
  localparam int B_EN    = 15;
  localparam int B_BLOCK = 13;
  localparam int B_ORDER = 14;
  localparam int B_ALL   = 16;
  // writable bits and reset values
  localparam logic [SLOT_W-1:0] MASK_HEAD = 17'h1FFFF;
  localparam logic [SLOT_W-1:0] MASK_PLAIN = 17'h09FFF;
  localparam logic [SLOT_W-1:0] RST_HEAD = 17'h03FFF;
  localparam logic [SLOT_W-1:0] RST_PLAIN = 17'h01FFF;

  // accept decision with its precedence order
  function automatic logic decide(input logic block, input logic all, input logic hit);
    if (block) return 1'b0;
    if (all) return 1'b1;
    return hit;
  endfunction

  // prev holds the three earlier bytes, oldest in bits 23:16
  function automatic logic [31:0] pack_word(input logic [23:0] prev, input logic [7:0] last,
                                            input logic little);
    if (little) return {last, prev[7:0], prev[15:8], prev[23:16]};
    return {prev, last};
  endfunction
endpackage

// File: rtl/tsf_slot_bank.sv
module tsf_slot_bank
  import tsf_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int AW = $clog2(NUM_SLOTS) + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [PID_W-1:0] pid,
  output logic             hit,
  output logic             block_all,
  output logic             pass_all,
  output logic             little_end
);
  localparam int SW = AW - 2;

  logic [SW-1:0] sel;
  logic [SLOT_W-1:0] slot_w [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] hit_vec;

  assign sel = addr[AW-1:2];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam logic [SLOT_W-1:0] MASK = (g == 0) ? MASK_HEAD : MASK_PLAIN;
    localparam logic [SLOT_W-1:0] RSTV = (g == 0) ? RST_HEAD : RST_PLAIN;
    logic [SLOT_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= RSTV;
      else if (we && int'(sel) == g) q <= wdata[SLOT_W-1:0] & MASK;
    end
    assign slot_w[g] = q;
    assign hit_vec[g] = q[B_EN] && (q[PID_W-1:0] == pid);
  end

  assign hit        = |hit_vec;
  assign block_all  = slot_w[0][B_BLOCK];
  assign pass_all   = slot_w[0][B_ALL];
  assign little_end = slot_w[0][B_ORDER];

  always_comb begin
    rdata = '0;
    if (int'(sel) < NUM_SLOTS) rdata[SLOT_W-1:0] = slot_w[sel];
  end

  // R2: a write is seen on the next read of the same address
  a_r2_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(sel) != 0) |=> (rdata[SLOT_W-1:0] == ($past(wdata[SLOT_W-1:0]) & MASK_PLAIN))
      || (sel != $past(sel)));
endmodule

// File: rtl/tsf_framer.sv
module tsf_framer
  import tsf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       in_byte,
  input  logic             in_valid,
  input  logic             in_start,
  input  logic             hit,
  input  logic             block_all,
  input  logic             pass_all,
  output logic [PID_W-1:0] pid_cur,
  output logic             byte_ok,
  output logic [CNT_W-1:0] byte_idx,
  output logic             pass_q
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic active_q, sync_ok_q;
  logic [4:0] pid_hi_q;

  assign byte_ok  = in_valid && (in_start || active_q);
  assign byte_idx = in_start ? '0 : cnt_q;
  assign pid_cur  = {pid_hi_q, in_byte};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      active_q <= 1'b0;
      sync_ok_q <= 1'b0;
      pid_hi_q <= '0;
      pass_q <= 1'b0;
    end else if (byte_ok) begin
      if (byte_idx == LAST) begin
        active_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        active_q <= 1'b1;
        cnt_q <= byte_idx + CNT_W'(1);
      end
      if (byte_idx == '0) begin
        sync_ok_q <= (in_byte == SYNC_BYTE);
        pass_q <= 1'b0;
      end
      if (byte_idx == CNT_W'(1)) pid_hi_q <= in_byte[4:0];
      if (byte_idx == CNT_W'(2)) pass_q <= sync_ok_q && decide(block_all, pass_all, hit);
    end
  end

  // R4: block-all at decision time leaves the packet dropped
  a_r4_block_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ok && byte_idx == CNT_W'(2) && block_all) |=> !pass_q);
  // R6: a bad sync byte leaves the packet dropped
  a_r6_bad_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ok && byte_idx == CNT_W'(2) && !sync_ok_q) |=> !pass_q);
  // R10: an idle framer waits at byte 0
  a_r10_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (cnt_q == '0));
endmodule

// File: rtl/tsf_packer.sv
module tsf_packer
  import tsf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_ok,
  input  logic [CNT_W-1:0] byte_idx,
  input  logic [7:0]       in_byte,
  input  logic             pass,
  input  logic             little,
  output logic [31:0]      word_q,
  output logic             word_valid_q,
  output logic             done_q,
  output logic             done_pass_q
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_LEN - 1);

  logic [23:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      word_q <= '0;
      word_valid_q <= 1'b0;
      done_q <= 1'b0;
      done_pass_q <= 1'b0;
    end else begin
      word_valid_q <= 1'b0;
      done_q <= 1'b0;
      if (byte_ok) begin
        hold_q <= {hold_q[15:0], in_byte};
        if (byte_idx[1:0] == 2'd3 && pass) begin
          word_q <= pack_word(hold_q, in_byte, little);
          word_valid_q <= 1'b1;
        end
        if (byte_idx == LAST) begin
          done_q <= 1'b1;
          done_pass_q <= pass;
        end
      end
    end
  end

  // R7: words never come on back-to-back cycles
  a_r7_word_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_q |=> !word_valid_q);
  // R9: an accepted packet's end pulse comes with its last word
  a_r9_done_with_word: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && done_pass_q) |-> word_valid_q);
endmodule

// File: rtl/tsf_pid_filter.sv
module tsf_pid_filter
  import tsf_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int AW = $clog2(NUM_SLOTS) + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    ts_byte,
  input  logic          ts_valid,
  input  logic          ts_start,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  output logic [31:0]   cap_word,
  output logic          cap_valid,
  output logic          pkt_end,
  output logic          pkt_accepted
);
  logic [PID_W-1:0] pid_cur;
  logic hit, block_all, pass_all, little_end;
  logic byte_ok, pass_q;
  logic [CNT_W-1:0] byte_idx;

  tsf_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .AW(AW)) u_bank (
    .clk, .rst_n, .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .pid(pid_cur), .hit, .block_all, .pass_all, .little_end
  );

  tsf_framer u_framer (
    .clk, .rst_n, .in_byte(ts_byte), .in_valid(ts_valid), .in_start(ts_start),
    .hit, .block_all, .pass_all, .pid_cur, .byte_ok, .byte_idx, .pass_q
  );

  tsf_packer u_packer (
    .clk, .rst_n, .byte_ok, .byte_idx, .in_byte(ts_byte), .pass(pass_q), .little(little_end),
    .word_q(cap_word), .word_valid_q(cap_valid), .done_q(pkt_end), .done_pass_q(pkt_accepted)
  );

  // R5: pass-all without block-all accepts a packet with good sync
  a_r5_pass_all: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ok && byte_idx == CNT_W'(2) && pass_all && !block_all && u_framer.sync_ok_q)
      |=> pass_q);
endmodule

// File: tb/tb_tsf_pid_filter.sv
module tb_tsf_pid_filter;
  localparam int CLK_PERIOD = 10;
  localparam int PKT = 188;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] ts_byte = '0;
  logic ts_valid = 1'b0, ts_start = 1'b0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata, cap_word;
  logic cap_valid, pkt_end, pkt_accepted;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tsf_pid_filter dut (.*);

  int n_cmp = 0, n_bad = 0, n_words = 0, n_ends = 0;
  logic [31:0] exp_w[$];
  string tag_w[$];
  logic exp_d[$];
  string tag_d[$];
  logic [16:0] model [8];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare every output pulse against the expected queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (cap_valid) begin
        n_words++;
        if (exp_w.size() == 0) chk(0, "R7 unexpected word", cap_word, 32'h0);
        else begin
          automatic logic [31:0] e = exp_w.pop_front();
          automatic string t = tag_w.pop_front();
          chk(cap_word == e, t, cap_word, e);
        end
      end
      if (pkt_end) begin
        n_ends++;
        if (exp_d.size() == 0) chk(0, "R9 unexpected end pulse", 32'(pkt_accepted), 32'h0);
        else begin
          automatic logic e = exp_d.pop_front();
          automatic string t = tag_d.pop_front();
          chk(pkt_accepted == e, t, 32'(pkt_accepted), 32'(e));
        end
      end
    end
  end

  task automatic wr(input int slot, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(slot * 4 + 1); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model[slot] = d[16:0] & ((slot == 0) ? 17'h1FFFF : 17'h09FFF);
  endtask

  task automatic rd_chk(input int slot, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = 5'(slot * 4 + (slot % 4));
    #1;
    chk(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  // driver: builds a packet, predicts its results, then drives it
  task automatic send(input logic [12:0] pid, input logic [7:0] sync, input int len,
                      input int gap, input string tag);
    logic [7:0] b [PKT];
    bit hit = 0, pass;
    bit little = model[0][14];
    b[0] = sync; b[1] = {3'b101, pid[12:8]}; b[2] = pid[7:0];
    for (int i = 3; i < PKT; i++) b[i] = 8'(i * 7 + pid[3:0]);
    for (int s = 0; s < 8; s++) if (model[s][15] && model[s][12:0] == pid) hit = 1;
    pass = (sync == 8'h47) && !model[0][13] && (model[0][16] || hit);
    if (pass)
      for (int k = 0; k + 3 < len; k += 4) begin
        exp_w.push_back(little ? {b[k+3], b[k+2], b[k+1], b[k]} : {b[k], b[k+1], b[k+2], b[k+3]});
        tag_w.push_back({tag, " word"});
      end
    if (len == PKT) begin
      exp_d.push_back(pass);
      tag_d.push_back({tag, " accept flag (R9)"});
    end
    for (int i = 0; i < len; i++) begin
      if (gap != 0 && i % gap == 1) begin
        @(negedge clk); ts_valid = 1'b0; ts_start = 1'b0;
      end
      @(negedge clk);
      ts_valid = 1'b1; ts_start = (i == 0); ts_byte = b[i];
    end
    @(negedge clk);
    ts_valid = 1'b0; ts_start = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R7 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int w0, e0;
    model[0] = 17'h03FFF;
    for (int s = 1; s < 8; s++) model[s] = 17'h01FFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset contents and quiet outputs
    for (int s = 0; s < 8; s++) rd_chk(s, (s == 0) ? 32'h03FFF : 32'h01FFF, "R1 reset slot");
    chk(!cap_valid && !pkt_end, "R1 quiet outputs", {cap_valid, pkt_end}, 0);
    // R2: masking and addressing
    wr(2, 32'hFFFF_FFFF);
    rd_chk(2, 32'h09FFF, "R2 plain slot mask");
    wr(0, 32'hFFFF_FFFF);
    rd_chk(0, 32'h1FFFF, "R2 head slot mask");
    wr(2, 32'h0000_1FFF);
    rd_chk(2, 32'h01FFF, "R2 slot parked");
    wr(0, 32'h0);
    wr(3, 32'h0000_8123);
    wr(5, 32'h0000_0456);
    wr(7, 32'h0000_9ABC);
    rd_chk(3, 32'h08123, "R2 slot 3 readback");
    // R3/R7/R8: match, big-endian order
    send(13'h0123, 8'h47, PKT, 0, "R3 R8 matched slot3 big-endian");
    send(13'h1ABC, 8'h47, PKT, 3, "R3 matched slot7 with gaps R10");
    send(13'h0456, 8'h47, PKT, 0, "R3 disabled slot drops");
    send(13'h0777, 8'h47, PKT, 0, "R3 no match drops");
    // R5: pass-all
    wr(0, 32'h0001_0000);
    send(13'h0777, 8'h47, PKT, 5, "R5 pass-all");
    // R4: block-all wins
    wr(0, 32'h0001_2000);
    send(13'h0123, 8'h47, PKT, 0, "R4 block-all over pass-all");
    // R8: little-endian order
    wr(0, 32'h0000_4000);
    send(13'h0123, 8'h47, PKT, 0, "R8 little-endian");
    // R6: bad sync
    send(13'h0123, 8'h48, PKT, 0, "R6 bad sync");
    // R10: stray bytes outside a packet
    w0 = n_words; e0 = n_ends;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); ts_valid = 1'b1; ts_start = 1'b0; ts_byte = 8'h47;
    end
    @(negedge clk); ts_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(n_words == w0 && n_ends == e0, "R10 stray bytes ignored", 32'(n_words - w0 + n_ends - e0), 0);
    // R10: restart in mid packet
    wr(0, 32'h0);
    send(13'h0123, 8'h47, 50, 0, "R10 cut packet");
    send(13'h1ABC, 8'h47, PKT, 0, "R10 restart packet");
    repeat (5) @(negedge clk);
    chk(exp_w.size() == 0, "R7 all expected words seen", 32'(exp_w.size()), 0);
    chk(exp_d.size() == 0, "R9 all expected end pulses seen", 32'(exp_d.size()), 0);
    summary();
    $finish;
  end
endmodule